// File: doc/BRIEF.md
# Tile Scroll Address Register Unit

This block keeps the scroll and video-memory address state of a tile-based display controller. It has four registers: a 15-bit current address that the fetch logic uses, a 15-bit staging address that the processor builds up, a 3-bit fine horizontal scroll, and a one-bit write phase. The fine horizontal scroll picks the pixel within a tile.

The processor side has three write strobes and one read strobe. The scroll-port write and the address-port write both pack a data byte into the staging address, and they share the write phase, so writes to the two ports may interleave. The data-port access strobe advances the current address. A status read puts the write phase back to its first state. The render side uses strobes that step the current address one tile to the right or one pixel row down, and strobes that copy the horizontal or vertical fields from the staging address. A frame timer outside the block provides the rendering-active flag. While that flag is set, a data-port access steps the address in both directions instead of adding a fixed amount.

Address layout, from the most significant bit down:
- bits 14:12: fine row
- bit 11: vertical page select
- bit 10: horizontal page select
- bits 9:5: tile row
- bits 4:0: tile column

Top module: `scroll_addr_unit`

## Requirements
- R1: After reset the current address, the staging address, the fine horizontal scroll and the write phase are all zero.
- R2: An address-port write in phase 0 writes data[5:0] into staging bits 13:8 and clears staging bit 14. It sets the phase to 1 and leaves the current address unchanged. After writing 0x04 the staging address is 0x0400.
- R3: An address-port write in phase 1 writes the data byte into staging bits 7:0 and clears the phase. The new staging word is loaded into the current address at the same clock edge, and this also happens while rendering.
- R4: A scroll-port write in phase 0 writes data[7:3] into the tile column and data[2:0] into the fine horizontal scroll. A scroll-port write in phase 1 writes data[2:0] into the fine row and data[7:3] into the tile row. The current address is not changed by either write.
- R5: Scroll-port and address-port writes advance the same phase bit. Starting from 0x0400 with phase 1, the scroll writes 0x3E and then 0x7D give staging 0x64EF and fine horizontal scroll 5.
- R6: A status read clears the write phase, so the next address-port write is treated as a phase 0 write.
- R7: Increment-X adds one to the tile column. When the tile column is 31 it wraps to 0 and bit 10 is inverted, so 0x5A3F becomes 0x5E20.
- R8: Increment-Y adds one to the fine row while the fine row is below 7. When the fine row is 7 it goes to 0 and the tile row changes as follows:
  - A tile row of 29 wraps to 0 and bit 11 is inverted.
  - A tile row of 31 wraps to 0 and bit 11 is not changed.
  - Any other tile row adds one.
  For example, 0x77A3 becomes 0x0C03 and 0x7FE5 becomes 0x0C05.
- R9: While rendering is not active, a data-port access adds 1 to the current address. It adds 32 instead when the row-step input is 1. The sum wraps within 15 bits.
- R10: While rendering is active, a data-port access applies increment-X and then increment-Y, and the row-step input has no effect. For example, 0x0000 becomes 0x1001 and 0x23A0 becomes 0x33A1.
- R11: Copy-horizontal loads bit 10 and bits 4:0 of the current address from the staging address. Copy-vertical loads bits 14:11 and bits 9:5 of the current address from the staging address.
- R12: When strobes arrive in the same cycle, the phase-1 address write takes effect over every render strobe. A render strobe takes effect over a data-port step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scroll_wr_i | input | 1 | Scroll-port write strobe |
| addr_wr_i | input | 1 | Address-port write strobe |
| data_acc_i | input | 1 | Data-port access strobe |
| status_rd_i | input | 1 | Status read strobe; clears the write phase |
| cpu_data_i | input | 8 | Write data byte |
| row_step_i | input | 1 | 1 selects a step of 32 for a data-port access outside rendering |
| render_active_i | input | 1 | Rendering-active flag from the frame timer |
| inc_x_i | input | 1 | Step the address one tile right |
| inc_y_i | input | 1 | Step the address one pixel row down |
| copy_h_i | input | 1 | Copy the horizontal fields from staging |
| copy_v_i | input | 1 | Copy the vertical fields from staging |
| cur_addr_o | output | 15 | Current address |
| fine_x_o | output | 3 | Fine horizontal scroll |

## Verification
The staging address cannot be read directly at the ports. The bench makes it visible by pulsing both copy strobes together, which loads the whole staging word into the current address. A helper writes any 15-bit value into both registers using two address writes, two scroll writes and a copy. That value includes fine-row bit 14, which the address port alone can never set. The helper is used to reach the wrap cases: tile column 31, tile rows 29 and 31, and a linear step past 0x7FFF. The collision cases drive several strobes in the same cycle. In these cases the two possible winners lead to different addresses, so the result shows which one took effect.

// File: rtl/scroll_pkg.sv
package scroll_pkg;
  localparam int FINE_W  = 3;
  localparam int CRS_W   = 5;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 2 * CRS_W + 2 + FINE_W;
  localparam int CX_LSB  = 0;
  localparam int CY_LSB  = CRS_W;
  localparam int NTH_BIT = 2 * CRS_W;
  localparam int NTV_BIT = 2 * CRS_W + 1;
  localparam int FY_LSB  = 2 * CRS_W + 2;
  localparam int ROW_STEP = 1 << CRS_W;
  typedef logic [ADDR_W-1:0] vaddr_t;
endpackage

// File: rtl/scroll_tmp_reg.sv
module scroll_tmp_reg
  import scroll_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scroll_wr_i,
  input  logic              addr_wr_i,
  input  logic              status_rd_i,
  input  logic [DATA_W-1:0] data_i,
  output vaddr_t            tmp_o,
  output logic [FINE_W-1:0] fine_x_o,
  output logic              toggle_o,
  output logic              load_v_o,
  output vaddr_t            load_val_o
);
  vaddr_t            tmp_q, tmp_d;
  logic [FINE_W-1:0] fx_q, fx_d;
  logic              tog_q, tog_d;

  always_comb begin
    tmp_d = tmp_q;
    fx_d  = fx_q;
    tog_d = tog_q;
    if (status_rd_i) begin
      tog_d = 1'b0;
    end else if (addr_wr_i) begin
      if (!tog_q) begin
        tmp_d[ADDR_W-2:DATA_W] = data_i[ADDR_W-2-DATA_W:0];
        tmp_d[ADDR_W-1]        = 1'b0;
        tog_d                  = 1'b1;
      end else begin
        tmp_d[DATA_W-1:0] = data_i;
        tog_d             = 1'b0;
      end
    end else if (scroll_wr_i) begin
      if (!tog_q) begin
        tmp_d[CX_LSB +: CRS_W] = data_i[DATA_W-1 -: CRS_W];
        fx_d                   = data_i[FINE_W-1:0];
        tog_d                  = 1'b1;
      end else begin
        tmp_d[FY_LSB +: FINE_W] = data_i[FINE_W-1:0];
        tmp_d[CY_LSB +: CRS_W]  = data_i[DATA_W-1 -: CRS_W];
        tog_d                   = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmp_q <= '0;
      fx_q  <= '0;
      tog_q <= 1'b0;
    end else begin
      tmp_q <= tmp_d;
      fx_q  <= fx_d;
      tog_q <= tog_d;
    end
  end

  assign tmp_o      = tmp_q;
  assign fine_x_o   = fx_q;
  assign toggle_o   = tog_q;
  assign load_v_o   = addr_wr_i & tog_q & ~status_rd_i;
  assign load_val_o = tmp_d;
endmodule

// File: rtl/scroll_v_next.sv
module scroll_v_next
  import scroll_pkg::*;
#(
  parameter int TILE_ROWS = 30
) (
  input  vaddr_t cur_i,
  input  vaddr_t tmp_i,
  input  logic   inc_x_i,
  input  logic   inc_y_i,
  input  logic   copy_h_i,
  input  logic   copy_v_i,
  input  logic   data_acc_i,
  input  logic   render_active_i,
  input  logic   row_step_i,
  output vaddr_t nxt_o
);
  localparam logic [CRS_W-1:0] LAST_ROW = CRS_W'(TILE_ROWS - 1);

  function automatic vaddr_t step_x(input vaddr_t a);
    vaddr_t r = a;
    if (a[CX_LSB +: CRS_W] == '1) begin
      r[CX_LSB +: CRS_W] = '0;
      r[NTH_BIT]         = ~a[NTH_BIT];
    end else begin
      r[CX_LSB +: CRS_W] = a[CX_LSB +: CRS_W] + CRS_W'(1);
    end
    return r;
  endfunction

  function automatic vaddr_t step_y(input vaddr_t a);
    vaddr_t r = a;
    if (a[FY_LSB +: FINE_W] != '1) begin
      r[FY_LSB +: FINE_W] = a[FY_LSB +: FINE_W] + FINE_W'(1);
    end else begin
      r[FY_LSB +: FINE_W] = '0;
      if (a[CY_LSB +: CRS_W] == LAST_ROW) begin
        r[CY_LSB +: CRS_W] = '0;
        r[NTV_BIT]         = ~a[NTV_BIT];
      end else if (a[CY_LSB +: CRS_W] == '1) begin
        r[CY_LSB +: CRS_W] = '0;
      end else begin
        r[CY_LSB +: CRS_W] = a[CY_LSB +: CRS_W] + CRS_W'(1);
      end
    end
    return r;
  endfunction

  logic render_op;
  assign render_op = inc_x_i | inc_y_i | copy_h_i | copy_v_i;

  always_comb begin
    nxt_o = cur_i;
    if (render_op) begin
      if (inc_x_i) nxt_o = step_x(nxt_o);
      if (inc_y_i) nxt_o = step_y(nxt_o);
      if (copy_h_i) begin
        nxt_o[NTH_BIT]         = tmp_i[NTH_BIT];
        nxt_o[CX_LSB +: CRS_W] = tmp_i[CX_LSB +: CRS_W];
      end
      if (copy_v_i) begin
        nxt_o[FY_LSB +: FINE_W] = tmp_i[FY_LSB +: FINE_W];
        nxt_o[NTV_BIT]          = tmp_i[NTV_BIT];
        nxt_o[CY_LSB +: CRS_W]  = tmp_i[CY_LSB +: CRS_W];
      end
    end else if (data_acc_i) begin
      if (render_active_i) nxt_o = step_y(step_x(cur_i));
      else if (row_step_i) nxt_o = cur_i + ADDR_W'(ROW_STEP);
      else                 nxt_o = cur_i + ADDR_W'(1);
    end
  end
endmodule

// File: rtl/scroll_addr_unit.sv
module scroll_addr_unit
  import scroll_pkg::*;
#(
  parameter int TILE_ROWS = 30
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        scroll_wr_i,
  input  logic        addr_wr_i,
  input  logic        data_acc_i,
  input  logic        status_rd_i,
  input  logic [7:0]  cpu_data_i,
  input  logic        row_step_i,
  input  logic        render_active_i,
  input  logic        inc_x_i,
  input  logic        inc_y_i,
  input  logic        copy_h_i,
  input  logic        copy_v_i,
  output logic [14:0] cur_addr_o,
  output logic [2:0]  fine_x_o
);
  vaddr_t tmp_addr, load_val, v_nxt, v_q;
  logic   toggle_q, load_v;

  scroll_tmp_reg u_tmp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scroll_wr_i(scroll_wr_i),
    .addr_wr_i  (addr_wr_i),
    .status_rd_i(status_rd_i),
    .data_i     (cpu_data_i),
    .tmp_o      (tmp_addr),
    .fine_x_o   (fine_x_o),
    .toggle_o   (toggle_q),
    .load_v_o   (load_v),
    .load_val_o (load_val)
  );

  scroll_v_next #(.TILE_ROWS(TILE_ROWS)) u_next (
    .cur_i          (v_q),
    .tmp_i          (tmp_addr),
    .inc_x_i        (inc_x_i),
    .inc_y_i        (inc_y_i),
    .copy_h_i       (copy_h_i),
    .copy_v_i       (copy_v_i),
    .data_acc_i     (data_acc_i),
    .render_active_i(render_active_i),
    .row_step_i     (row_step_i),
    .nxt_o          (v_nxt)
  );

  // address-port load wins over every render strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     v_q <= '0;
    else if (load_v) v_q <= load_val;
    else             v_q <= v_nxt;
  end

  assign cur_addr_o = v_q;
endmodule

// File: rtl/scroll_addr_unit_chk.sv
module scroll_addr_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        scroll_wr_i,
  input logic        addr_wr_i,
  input logic        data_acc_i,
  input logic        status_rd_i,
  input logic [7:0]  cpu_data_i,
  input logic        inc_x_i,
  input logic        inc_y_i,
  input logic        copy_h_i,
  input logic        copy_v_i,
  input logic [14:0] cur_addr_o,
  input logic [2:0]  fine_x_o,
  input logic [14:0] tmp_addr,
  input logic        toggle_q
);
  logic other_strobe;
  assign other_strobe = data_acc_i | inc_x_i | inc_y_i | copy_h_i | copy_v_i;

  // R3
  load_v_from_tmp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_wr_i && toggle_q && !status_rd_i) |=> (cur_addr_o == tmp_addr));

  // R6
  status_clears_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_rd_i |=> !toggle_q);

  // R5
  shared_phase_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((scroll_wr_i ^ addr_wr_i) && !status_rd_i) |=> (toggle_q != $past(toggle_q)));

  // R2
  first_addr_keeps_v_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_wr_i && !toggle_q && !other_strobe) |=> $stable(cur_addr_o));

  // R4
  scroll_fine_x_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scroll_wr_i && !addr_wr_i && !status_rd_i && !toggle_q) |=> (fine_x_o == $past(cpu_data_i[2:0])));

  // R8
  fine_row_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_y_i && !copy_v_i && !addr_wr_i && cur_addr_o[14:12] != 3'd7)
      |=> (cur_addr_o[14:12] == $past(cur_addr_o[14:12]) + 3'd1));
endmodule

bind scroll_addr_unit scroll_addr_unit_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scroll_wr_i(scroll_wr_i),
  .addr_wr_i  (addr_wr_i),
  .data_acc_i (data_acc_i),
  .status_rd_i(status_rd_i),
  .cpu_data_i (cpu_data_i),
  .inc_x_i    (inc_x_i),
  .inc_y_i    (inc_y_i),
  .copy_h_i   (copy_h_i),
  .copy_v_i   (copy_v_i),
  .cur_addr_o (cur_addr_o),
  .fine_x_o   (fine_x_o),
  .tmp_addr   (tmp_addr),
  .toggle_q   (toggle_q)
);

// File: tb/scroll_addr_unit_test.sv
`timescale 1ns/1ps
module scroll_addr_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw = 0, aw = 0, da = 0, sr = 0, st = 0, rn = 0;
  logic        ix = 0, iy = 0, ch = 0, cv = 0;
  logic [7:0]  d = '0;
  logic [14:0] cur;
  logic [2:0]  fx;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [14:0] q_v[$];
  logic [2:0]  q_f[$];
  string       q_t[$];

  always #10 clk = ~clk;

  scroll_addr_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .scroll_wr_i(sw), .addr_wr_i(aw),
    .data_acc_i(da), .status_rd_i(sr), .cpu_data_i(d), .row_step_i(st),
    .render_active_i(rn), .inc_x_i(ix), .inc_y_i(iy), .copy_h_i(ch),
    .copy_v_i(cv), .cur_addr_o(cur), .fine_x_o(fx)
  );

  // monitor: compares results one cycle after each drive
  always @(negedge clk) begin
    if (q_v.size() > 0) begin
      logic [14:0] ev;
      logic [2:0]  ef;
      string       tg;
      ev = q_v.pop_front();
      ef = q_f.pop_front();
      tg = q_t.pop_front();
      checks++;
      if (cur !== ev || fx !== ef) begin
        fails++;
        $display("FAIL %s: addr=%h fine_x=%0d expected addr=%h fine_x=%0d", tg, cur, fx, ev, ef);
      end
    end
  end

  task automatic op(input logic s_w, a_w, d_a, s_r, input logic [7:0] dat,
                    input logic stp, rnd, i_x, i_y, c_h, c_v,
                    input bit chk, input logic [14:0] ev, input logic [2:0] ef, input string tg);
    @(negedge clk);
    sw = s_w; aw = a_w; da = d_a; sr = s_r; d = dat;
    st = stp; rn = rnd; ix = i_x; iy = i_y; ch = c_h; cv = c_v;
    @(posedge clk);
    #1;
    sw = 0; aw = 0; da = 0; sr = 0; d = '0;
    st = 0; rn = 0; ix = 0; iy = 0; ch = 0; cv = 0;
    if (chk) begin
      q_v.push_back(ev);
      q_f.push_back(ef);
      q_t.push_back(tg);
    end
  endtask

  task automatic aw_op(input logic [7:0] dat, input bit chk, input logic [14:0] ev,
                       input logic [2:0] ef, input string tg);
    op(0, 1, 0, 0, dat, 0, 0, 0, 0, 0, 0, chk, ev, ef, tg);
  endtask

  task automatic sw_op(input logic [7:0] dat, input bit chk, input logic [14:0] ev,
                       input logic [2:0] ef, input string tg);
    op(1, 0, 0, 0, dat, 0, 0, 0, 0, 0, 0, chk, ev, ef, tg);
  endtask

  task automatic copy_op(input bit h, input bit v, input logic [14:0] ev,
                         input logic [2:0] ef, input string tg);
    op(0, 0, 0, 0, 8'h00, 0, 0, 0, 0, h, v, 1, ev, ef, tg);
  endtask

  // writes a full 15-bit value into staging and current address, fine x = 0
  task automatic set_v(input logic [14:0] val);
    aw_op({2'b00, val[13:8]}, 0, '0, '0, "");
    aw_op(val[7:0], 0, '0, '0, "");
    sw_op({val[4:0], 3'b000}, 0, '0, '0, "");
    sw_op({val[9:5], val[14:12]}, 0, '0, '0, "");
    copy_op(1, 1, val, 3'd0, "R11 set_v");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1
    op(0, 0, 0, 0, 8'h00, 0, 0, 0, 0, 0, 0, 1, 15'h0000, 3'd0, "R1 reset");
    // R2
    aw_op(8'h04, 1, 15'h0000, 3'd0, "R2 first addr write keeps v");
    copy_op(1, 1, 15'h0400, 3'd0, "R2 staging 0x0400");
    // R5 / R4
    sw_op(8'h3E, 1, 15'h0400, 3'd0, "R4 scroll write keeps v");
    copy_op(1, 1, 15'h64E0, 3'd0, "R5 interleaved second scroll");
    sw_op(8'h7D, 1, 15'h64E0, 3'd5, "R4 first scroll fine x");
    copy_op(1, 1, 15'h64EF, 3'd5, "R5 staging 0x64EF");
    // R9 then R3
    op(0, 0, 1, 0, 8'h00, 1, 0, 0, 0, 0, 0, 1, 15'h650F, 3'd5, "R9 step 32");
    aw_op(8'hEF, 1, 15'h64EF, 3'd5, "R3 second addr write loads v");
    // R6
    aw_op(8'h3F, 1, 15'h64EF, 3'd5, "R6 first addr");
    op(0, 0, 0, 1, 8'h00, 0, 0, 0, 0, 0, 0, 1, 15'h64EF, 3'd5, "R6 status read");
    aw_op(8'h21, 1, 15'h64EF, 3'd5, "R6 phase restarted");
    aw_op(8'h80, 1, 15'h2180, 3'd5, "R6 second addr");
    // R7
    set_v(15'h5A3F);
    op(0, 0, 0, 0, 8'h00, 0, 1, 1, 0, 0, 0, 1, 15'h5E20, 3'd0, "R7 column wrap");
    op(0, 0, 0, 0, 8'h00, 0, 1, 1, 0, 0, 0, 1, 15'h5E21, 3'd0, "R7 column step");
    // R8
    set_v(15'h77A3);
    op(0, 0, 0, 0, 8'h00, 0, 1, 0, 1, 0, 0, 1, 15'h0C03, 3'd0, "R8 row 29 wrap");
    set_v(15'h7FE5);
    op(0, 0, 0, 0, 8'h00, 0, 1, 0, 1, 0, 0, 1, 15'h0C05, 3'd0, "R8 row 31 wrap");
    op(0, 0, 0, 0, 8'h00, 0, 1, 0, 1, 0, 0, 1, 15'h1C05, 3'd0, "R8 fine row step");
    // R9
    set_v(15'h7FFF);
    op(0, 0, 1, 0, 8'h00, 0, 0, 0, 0, 0, 0, 1, 15'h0000, 3'd0, "R9 wrap +1");
    set_v(15'h0010);
    op(0, 0, 1, 0, 8'h00, 1, 0, 0, 0, 0, 0, 1, 15'h0030, 3'd0, "R9 +32");
    // R10
    set_v(15'h0000);
    op(0, 0, 1, 0, 8'h00, 1, 1, 0, 0, 0, 0, 1, 15'h1001, 3'd0, "R10 render step");
    set_v(15'h23A0);
    op(0, 0, 1, 0, 8'h00, 0, 1, 0, 0, 0, 0, 1, 15'h33A1, 3'd0, "R10 render step");
    // R11
    set_v(15'h7FFF);
    sw_op(8'h00, 1, 15'h7FFF, 3'd0, "R11 scroll keeps v");
    sw_op(8'h00, 1, 15'h7FFF, 3'd0, "R11 scroll keeps v");
    copy_op(1, 0, 15'h7FE0, 3'd0, "R11 copy horizontal");
    copy_op(0, 1, 15'h0C00, 3'd0, "R11 copy vertical");
    // R12
    set_v(15'h0000);
    op(0, 0, 1, 0, 8'h00, 0, 0, 0, 0, 0, 0, 1, 15'h0001, 3'd0, "R12 setup");
    aw_op(8'h21, 1, 15'h0001, 3'd0, "R12 setup");
    op(0, 1, 0, 0, 8'h80, 0, 1, 1, 0, 0, 0, 1, 15'h2180, 3'd0, "R12 load beats inc_x");
    op(0, 0, 1, 0, 8'h00, 0, 1, 0, 1, 0, 0, 1, 15'h3180, 3'd0, "R12 inc_y beats data step");
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule